// File: doc/BRIEF.md
# Dual-Clock Put/Take FIFO

This block moves data words in one direction between two clock domains that have no fixed timing relationship. A transmitter in the write domain offers a word by raising `put` with the word on `wr_data`. The FIFO takes the word on a write-clock edge only when `put_ready` is high. A receiver in the read domain sees `take_valid` high whenever a stored word is waiting, reads it from `rd_data`, and raises `take` to remove it.

Each side keeps a binary pointer with one extra wrap bit and a Gray-coded copy of it. The Gray copy crosses into the other domain through a two-flop synchronizer. The write side compares its own pointer with the synchronized read pointer to detect full. The read side compares its own pointer with the synchronized write pointer to detect empty.

Every accepted transfer pulls its own flag low for one cycle. The flag comes back only after full or empty has been evaluated again against the updated pointer. Because of this, each side completes at most one transfer every two of its own clock cycles. The capacity is a power-of-two parameter, and a capacity of one entry is supported.

Top module: `xdom_put_take_fifo`

## Requirements
- R1: After both active-low resets are released, `put_ready` is 1 and `take_valid` is 0.
- R2: A word is accepted on a rising `wr_clk` edge where `put` and `put_ready` are both 1. In the next write-clock cycle `put_ready` is 0.
- R3: After DEPTH accepted words and no removal, `put_ready` stays 0. After one word is taken, `put_ready` returns to 1 within four write-clock cycles.
- R4: When a word is written into an empty FIFO, `take_valid` rises within five read-clock cycles. Once the FIFO is empty again, `take_valid` stays 0 until a new word arrives.
- R5: While `take_valid` is 1, `rd_data` shows the oldest stored word. A removal happens on a rising `rd_clk` edge where `take` and `take_valid` are both 1, and `take_valid` is 0 in the next read-clock cycle.
- R6: `put` while `put_ready` is 0 stores nothing and leaves the write pointer unchanged. `take` while `take_valid` is 0 removes nothing and leaves the read pointer unchanged.
- R7: Under concurrent traffic from both sides, words leave in the order they were written, with none lost and none duplicated.
- R8: Each pointer copy that crosses domains changes in at most one bit per clock edge of its own domain.
- R9: DEPTH may be any power of two down to 1. With DEPTH = 1, a single accepted word makes the FIFO full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain reset, active low |
| put | input | 1 | Transmitter offers a word |
| wr_data | input | DW | Word offered by the transmitter |
| put_ready | output | 1 | FIFO can accept a word this cycle |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain reset, active low |
| take | input | 1 | Receiver removes the presented word |
| rd_data | output | DW | Oldest stored word |
| take_valid | output | 1 | A stored word is presented |

## Verification
A corrupted pointer or a missed synchronizer update shows up at the ports as a wrong word on `rd_data`, a lost or repeated word, or a flag stuck at its old value. Each of these appears within a few cycles of the transfer that caused it. Words are numbered arithmetically, so a single skipped or duplicated word is caught at the very next read. A wrong full or empty decision is caught on the first fill or drain: `put_ready` stays high past DEPTH words, or `take_valid` stays high after the last word is read.

// File: rtl/xdom_put_take_fifo.sv
module xdom_put_take_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          put,
  input  logic [DW-1:0] wr_data,
  output logic          put_ready,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          take,
  output logic [DW-1:0] rd_data,
  output logic          take_valid
);
  localparam int PW = $clog2(DEPTH) + 1;
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] ONES  = '1;
  localparam logic [PW-1:0] FMASK = ~(ONES >> 2);

  logic [DW-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
  logic          w_hold, r_hold;
  logic          full, empty, w_acc, r_acc;
  logic [PW-1:0] wbin_n, rbin_n;
  logic [IW-1:0] widx, ridx;

  assign full       = (wgray == (rg_s2 ^ FMASK));
  assign empty      = (rgray == wg_s2);
  assign put_ready  = !w_hold && !full;
  assign take_valid = !r_hold && !empty;
  assign w_acc      = put && put_ready;
  assign r_acc      = take && take_valid;
  assign wbin_n     = wbin + PW'(1);
  assign rbin_n     = rbin + PW'(1);
  assign widx       = (DEPTH > 1) ? wbin[IW-1:0] : '0;
  assign ridx       = (DEPTH > 1) ? rbin[IW-1:0] : '0;
  assign rd_data    = mem[ridx];

  always_ff @(posedge wr_clk) begin
    if (w_acc) mem[widx] <= wr_data;
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      w_hold <= 1'b0;
      rg_s1  <= '0;
      rg_s2  <= '0;
    end else begin
      rg_s1  <= rgray;
      rg_s2  <= rg_s1;
      w_hold <= w_acc;
      if (w_acc) begin
        wbin  <= wbin_n;
        wgray <= wbin_n ^ (wbin_n >> 1);
      end
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      r_hold <= 1'b0;
      wg_s1  <= '0;
      wg_s2  <= '0;
    end else begin
      wg_s1  <= wgray;
      wg_s2  <= wg_s1;
      r_hold <= r_acc;
      if (r_acc) begin
        rbin  <= rbin_n;
        rgray <= rbin_n ^ (rbin_n >> 1);
      end
    end
  end

  AST_PUT_DROPS_READY: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (put && put_ready) |=> !put_ready); // R2
  AST_TAKE_DROPS_VALID: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (take && take_valid) |=> !take_valid); // R5
  AST_IGNORED_PUT: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (put && !put_ready) |=> $stable(wbin)); // R6
  AST_IGNORED_TAKE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (take && !take_valid) |=> $stable(rbin)); // R6
  AST_WGRAY_ONE_BIT: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R8
  AST_RGRAY_ONE_BIT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R8
endmodule

// File: tb/tb_xdom_put_take_fifo.sv
module tb_xdom_put_take_fifo;
  logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
  always #5 wr_clk = ~wr_clk;
  always #6.5 rd_clk = ~rd_clk;

  logic       put [2];
  logic       take[2];
  logic [7:0] din [2];
  logic [7:0] dout[2];
  logic       okp [2];
  logic       okt [2];
  int total = 0, bad = 0;
  bit finished = 0;
  int dep[2] = '{4, 1};

  xdom_put_take_fifo #(.DW(8), .DEPTH(4)) dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .put(put[0]), .wr_data(din[0]), .put_ready(okp[0]),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .take(take[0]), .rd_data(dout[0]), .take_valid(okt[0]));
  xdom_put_take_fifo #(.DW(8), .DEPTH(1)) dut1 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .put(put[1]), .wr_data(din[1]), .put_ready(okp[1]),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .take(take[1]), .rd_data(dout[1]), .take_valid(okt[1]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_put(input int u, input logic [7:0] d);
    while (1) begin @(negedge wr_clk); if (okp[u]) break; end
    put[u] = 1; din[u] = d;
    @(negedge wr_clk);
    put[u] = 0;
    chk(okp[u] == 0, "R2 ready drop", okp[u], 0);
  endtask

  task automatic do_take(input int u, input logic [7:0] e, input string req);
    while (1) begin @(negedge rd_clk); if (okt[u]) break; end
    chk(dout[u] == e, req, dout[u], e);
    take[u] = 1;
    @(negedge rd_clk);
    take[u] = 0;
    chk(okt[u] == 0, "R5 valid drop", okt[u], 0);
  endtask

  task automatic run_unit(input int u);
    int n;
    for (int i = 0; i < dep[u]; i++) do_put(u, 8'(8'h10 + i));
    repeat (8) @(negedge wr_clk);
    chk(okp[u] == 0, (u == 1) ? "R9 depth-1 full" : "R3 full", okp[u], 0);
    put[u] = 1; din[u] = 8'hEE;
    repeat (4) @(negedge wr_clk);
    put[u] = 0;
    chk(okp[u] == 0, "R3 stays full", okp[u], 0);
    do_take(u, 8'h10, "R5 oldest word");
    n = 0;
    while (!okp[u] && n < 10) begin @(negedge wr_clk); n++; end
    chk(n <= 4, "R3 ready returns", n, 4);
    for (int i = 1; i < dep[u]; i++) do_take(u, 8'(8'h10 + i), "R6 ignored put stored nothing");
    repeat (8) @(negedge rd_clk);
    chk(okt[u] == 0, "R4 empty", okt[u], 0);
    take[u] = 1;
    repeat (3) @(negedge rd_clk);
    take[u] = 0;
    chk(okt[u] == 0, "R4 stays empty", okt[u], 0);
    do_put(u, 8'h55);
    n = 0;
    while (!okt[u] && n < 10) begin @(negedge rd_clk); n++; end
    chk(n <= 5, "R4 valid rises", n, 5);
    do_take(u, 8'h55, "R6 ignored take removed nothing");
    fork
      for (int i = 0; i < 60; i++) begin
        do_put(u, 8'((i * 7 + 3) & 255));
        repeat (i % 3) @(negedge wr_clk);
      end
      for (int i = 0; i < 60; i++) begin
        do_take(u, 8'((i * 7 + 3) & 255), "R7 R8 stream order");
        repeat (i % 5) @(negedge rd_clk);
      end
    join
  endtask

  initial begin
    put = '{0, 0}; take = '{0, 0}; din = '{0, 0};
    repeat (3) @(negedge wr_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    @(negedge wr_clk);
    for (int u = 0; u < 2; u++) begin
      chk(okp[u] == 1, "R1 reset ready", okp[u], 1);
      chk(okt[u] == 0, "R1 reset valid", okt[u], 0);
    end
    run_unit(0);
    run_unit(1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule